// File: doc/BRIEF.md
# Word Memory Access Sequencer

This block sits on the processor side of a word-addressed synchronous memory. It moves single words in and out of that memory through two private registers. One holds the address being accessed. The other holds the data word going out to memory or coming back from it. A requester raises a request with a direction bit, an address and, for stores, a word. The block then runs a fixed sequence of register transfers and strobes, and it pulses a completion flag when the transfer is finished.

For a store, the sequencer first captures the outgoing word in the data register. On the next cycle it moves the address into the address register. Only after that does it raise the write strobe for a single cycle. For a fetch, it loads the address register first and raises the read strobe for one cycle. It then waits a parameterised number of cycles before it copies the memory's output into the data register. The requester cannot write either register directly. It sees the data register only through the read data output.

Top module: `mem_xfer_seq`

## Requirements
- R1: A store loads the data register in the cycle after acceptance, while the address register still holds its old value. It loads the address register one cycle later. It then raises `mem_we` for exactly one cycle, with `mem_addr` and `mem_wdata` equal to the requested address and word.
- R2: A fetch loads the address register at acceptance, so `mem_addr` equals the requested address from the next cycle on. In that same next cycle `mem_re` is high for exactly one cycle. The data register takes `mem_rdata` `RD_LAT` cycles after the strobe cycle ends.
- R3: Count clock edges from the accepting edge, which is edge 1. `done` is high for exactly one cycle after edge 3 for a store and after edge 2+`RD_LAT` for a fetch.
- R4: `busy` is high from the cycle after acceptance through the `done` cycle. It is low at all other times.
- R5: A request presented while `busy` is high is ignored. It starts no strobe, does not change the transfer in progress, and leaves memory and the registers as they were.
- R6: After a store, `rd_data` shows the stored word. After a fetch, it shows the fetched word. The value holds until a later transfer loads the data register again.
- R7: Reset clears both registers, so `mem_addr` and `rd_data` read 0. It also returns the block to idle, with `busy`, `done`, `mem_we` and `mem_re` all low.
- R8: Every one of the 2^`ADDR_W` word addresses can be stored to and fetched back. A single transfer moves one whole `DATA_W`-bit word.
- R9: `mem_we` and `mem_re` are never high together, and neither is high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; sampled only while idle |
| req_write | input | 1 | 1 = store, 0 = fetch |
| req_addr | input | ADDR_W | Word address of the request |
| req_wdata | input | DATA_W | Word to store |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Contents of the data register |
| mem_addr | output | ADDR_W | Address register driven to memory |
| mem_wdata | output | DATA_W | Data register driven to memory |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_rdata | input | DATA_W | Memory output word, valid by the time the wait ends |

## Verification
The assertions take two things for granted. First, the memory keeps `mem_rdata` valid for the address on `mem_addr` by the end of the wait. Second, `RD_LAT` stays in the range 1 to 15. The bench memory is a behavioural array that is read combinationally from the current address register, so the first condition always holds. The bench uses a latency inside that range. No assumption is made about `req_valid`: the bench deliberately holds competing requests high during transfers to show that they are dropped.

// File: rtl/mxs_pkg.sv
package mxs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WMAR,
    ST_WSTB,
    ST_RSTB,
    ST_RWAIT,
    ST_DONE
  } seq_state_t;

  // width of a counter that must hold values 0 .. lat-1
  function automatic int wait_cnt_w(input int lat);
    return (lat < 2) ? 1 : $clog2(lat);
  endfunction

  // edges from acceptance (edge 1) to the edge that raises done
  function automatic int done_edge(input bit is_write, input int lat);
    return is_write ? 3 : 2 + lat;
  endfunction

endpackage

// File: rtl/mxs_ctrl.sv
module mxs_ctrl
  import mxs_pkg::*;
#(
  parameter int RD_LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  output logic ld_mdr_req,
  output logic ld_pend,
  output logic ld_mar_req,
  output logic ld_mar_pend,
  output logic fill_mdr,
  output logic mem_we,
  output logic mem_re,
  output logic busy,
  output logic done
);

  localparam int CW = wait_cnt_w(RD_LAT);
  localparam logic [CW-1:0] LAST = CW'(RD_LAT - 1);

  seq_state_t state;
  logic [CW-1:0] cnt;
  logic accept;
  logic wait_last;

  assign accept      = req_valid && (state == ST_IDLE);
  assign wait_last   = (state == ST_RWAIT) && (cnt == LAST);
  assign ld_mdr_req  = accept && req_write;
  assign ld_pend     = accept && req_write;
  assign ld_mar_req  = accept && !req_write;
  assign ld_mar_pend = (state == ST_WMAR);
  assign fill_mdr    = wait_last;
  assign mem_we      = (state == ST_WSTB);
  assign mem_re      = (state == ST_RSTB);
  assign busy        = (state != ST_IDLE);
  assign done        = (state == ST_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE:  if (accept) state <= req_write ? ST_WMAR : ST_RSTB;
        ST_WMAR:  state <= ST_WSTB;
        ST_WSTB:  state <= ST_DONE;
        ST_RSTB: begin
          state <= ST_RWAIT;
          cnt   <= '0;
        end
        ST_RWAIT: begin
          if (wait_last) state <= ST_DONE;
          else           cnt   <= cnt + 1'b1;
        end
        ST_DONE:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // R1: write strobe lasts one cycle
  p_we_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);
  // R2: read strobe lasts one cycle and is followed by waiting
  p_re_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> (!mem_re && busy));
  // R3: done is a single pulse that ends the busy window
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  // R4: busy persists until done
  p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  // R9: strobes exclusive and only while busy
  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
  p_strobe_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> busy);

endmodule

// File: rtl/mxs_regs.sv
module mxs_regs #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_mdr_req,
  input  logic              ld_pend,
  input  logic              ld_mar_req,
  input  logic              ld_mar_pend,
  input  logic              fill_mdr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mar_q,
  output logic [DATA_W-1:0] mdr_q
);

  logic [ADDR_W-1:0] pend_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mar_q     <= '0;
      mdr_q     <= '0;
      pend_addr <= '0;
    end else begin
      if (ld_pend)          pend_addr <= req_addr;
      if (ld_mar_req)       mar_q     <= req_addr;
      else if (ld_mar_pend) mar_q     <= pend_addr;
      if (ld_mdr_req)       mdr_q     <= req_wdata;
      else if (fill_mdr)    mdr_q     <= mem_rdata;
    end
  end

  // R1: on a store the address register follows the data register
  p_mdr_then_mar_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ld_mar_pend |-> $past(ld_mdr_req));
  // R2: the fetch fill never coincides with a new address load
  p_fill_no_mar_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_mdr |-> !(ld_mar_req || ld_mar_pend));

endmodule

// File: rtl/mem_xfer_seq.sv
module mem_xfer_seq #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int RD_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [DATA_W-1:0] mem_rdata
);

  logic ld_mdr_req_w, ld_pend_w, ld_mar_req_w, ld_mar_pend_w, fill_mdr_w;
  logic [ADDR_W-1:0] mar_w;
  logic [DATA_W-1:0] mdr_w;

  mxs_ctrl #(.RD_LAT(RD_LAT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .ld_mdr_req(ld_mdr_req_w), .ld_pend(ld_pend_w), .ld_mar_req(ld_mar_req_w),
    .ld_mar_pend(ld_mar_pend_w), .fill_mdr(fill_mdr_w),
    .mem_we(mem_we), .mem_re(mem_re), .busy(busy), .done(done)
  );

  mxs_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .ld_mdr_req(ld_mdr_req_w), .ld_pend(ld_pend_w),
    .ld_mar_req(ld_mar_req_w), .ld_mar_pend(ld_mar_pend_w), .fill_mdr(fill_mdr_w),
    .req_addr(req_addr), .req_wdata(req_wdata), .mem_rdata(mem_rdata),
    .mar_q(mar_w), .mdr_q(mdr_w)
  );

  assign mem_addr  = mar_w;
  assign mem_wdata = mdr_w;
  assign rd_data   = mdr_w;

  // R1: write strobe only right after the address register was loaded
  p_we_after_mar_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(ld_mar_pend_w));
  // R1: address register steady while the write strobe is high
  p_we_addr_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> $stable(mem_addr));
  // R5: no register loads from the requester while busy
  p_ignore_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(ld_mdr_req_w || ld_mar_req_w));

endmodule

// File: tb/sim_mem_xfer_seq.sv
module sim_mem_xfer_seq;
  localparam int AW  = 4;
  localparam int DW  = 8;
  localparam int LAT = 3;
  localparam int WORDS = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic busy, done, mem_we, mem_re;
  logic [DW-1:0] rd_data, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] ram [WORDS];

  int tests = 0, fails = 0;
  logic [AW-1:0] last_mar = '0;

  always #10 clk = ~clk;

  always @(posedge clk) if (mem_we) ram[mem_addr] <= mem_wdata;
  assign mem_rdata = ram[mem_addr];

  mem_xfer_seq #(.ADDR_W(AW), .DATA_W(DW), .RD_LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rd_data(rd_data), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata)
  );

  function automatic logic [DW-1:0] pat(input int a);
    return DW'((a * 37 + 5) % 256);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one transfer; optionally hold a competing request while busy
  task automatic txn(input bit wr, input int a, input logic [DW-1:0] d,
                     input bit intrude, input int ia, input logic [DW-1:0] id);
    int n = 0, strobes = 0;
    int exp_n = wr ? 3 : 2 + LAT;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = d;
    forever begin
      @(posedge clk); @(negedge clk); n++;
      if (n == 1) begin
        if (intrude) begin
          req_write = ~wr; req_addr = AW'(ia); req_wdata = id;
        end else req_valid = 1'b0;
        if (wr) begin
          chk(mem_wdata == d, "R1 data first", mem_wdata, d);
          chk(mem_addr == last_mar && !mem_we, "R1 address later", mem_addr, last_mar);
        end else
          chk(mem_addr == AW'(a) && mem_re, "R2 address then strobe", mem_addr, a);
      end
      if (mem_we || mem_re) begin
        strobes++;
        chk(mem_addr == AW'(a), "R1/R2 strobe address", mem_addr, a);
        if (wr) chk(mem_we && mem_wdata == d, "R1 strobe word", mem_wdata, d);
      end
      if (done || n > 40) break;
      chk(busy, "R4 busy during transfer", busy, 1);
    end
    req_valid = 1'b0;
    chk(n == exp_n, "R3 done cycle", n, exp_n);
    chk(busy, "R4 busy with done", busy, 1);
    chk(strobes == 1, "R1/R2 one strobe", strobes, 1);
    chk(rd_data == d, wr ? "R6 word kept after store" : "R8 fetched word", rd_data, d);
    last_mar = AW'(a);
    @(negedge clk);
    chk(!done && !busy, "R3 done single pulse", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_we && !mem_re, "R7 idle in reset", busy, 0);
    chk(mem_addr == '0 && rd_data == '0, "R7 registers cleared", rd_data, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_we && !mem_re, "R9 no strobe idle", mem_we, 0);

    for (int a = 0; a < WORDS; a++) txn(1'b1, a, pat(a), 1'b0, 0, '0);
    for (int a = WORDS - 1; a >= 0; a--) txn(1'b0, a, pat(a), 1'b0, 0, '0);

    // R5: competing fetch during a store, competing store during a fetch
    txn(1'b1, 5, 8'hA5, 1'b1, 6, 8'h3C);
    txn(1'b0, 6, pat(6), 1'b1, 9, 8'hC3);
    txn(1'b0, 9, pat(9), 1'b0, 0, '0);
    txn(1'b0, 5, 8'hA5, 1'b0, 0, '0);

    // R6: data register holds while idle
    repeat (5) @(negedge clk);
    chk(rd_data == 8'hA5 && !busy, "R6 hold when idle", rd_data, 8'hA5);

    // R7: reset after activity
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    chk(rd_data == '0 && mem_addr == '0 && !busy, "R7 reset clears", rd_data, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule